// File: doc/BRIEF.md
# PHY Bit-Serial Configuration Writer

This block programs a run of configuration bits inside one of several on-chip PHYs. The PHYs share one control/status register. Each configuration bit is written by placing its bit address and value in that register, then toggling a strobe that belongs to the target PHY. The block receives one request, made of a start bit address, a data word of up to 16 bits, a length and a PHY index. It then steps through the bits one at a time, least significant first. The address advances by one for each bit.

The register is modelled here as the block's own output, `csr_out`. No bus master is involved. A caller pulses `req_valid` while `busy` is low. It then waits for the one-cycle `done` pulse. A per-request hold count sets how long each strobe stays high, so the PHY has time to sample the data bit.

A build-time option zeroes the whole register before the first bit of every non-empty request. Some PHY families need this.

Top module: `phy_cfg_serial_writer`

## Requirements
- R1: After a synchronous active-low reset, `csr_out` is all zeros and `busy` and `done` are low.
- R2: The bit address being written sits in `csr_out[15:8]` and the data bit in `csr_out[7]`. The strobe for PHY n is `csr_out[2*n]`, so PHY 0 uses bit 0, PHY 1 bit 2, PHY 2 bit 4 and PHY 3 bit 6.
- R3: Bit i of the request writes `req_data[i]` at address `req_addr + i`, computed modulo 256, with i running from 0 upward. After the request ends, the address field and data bit keep the values of the last bit written.
- R4: Each bit is written in this order, and each step is taken on its own clock edge: load the address field; drive the strobe low; set the data bit; drive the strobe high; drive the strobe low. The strobe stays high for `hold_cycles + 1` cycles, so one bit takes `hold_cycles + 5` cycles.
- R5: `busy` rises in the cycle after a request is accepted. It falls on the same edge as the last strobe falls. `done` is high for exactly that one cycle.
- R6: A request with length 0 raises `done` in the next cycle. It produces no strobe, leaves `busy` low and leaves `csr_out` unchanged.
- R7: A length above 16 is treated as 16.
- R8: A `req_valid` that arrives while `busy` is high is ignored.
- R9: At most one strobe bit is high at any time. During a request, bits outside [15:7] and outside the active strobe keep their values.
- R10: With `CLEAR_ON_START` set, `csr_out` reads all zeros for one cycle after a non-empty request is accepted. Only then is the first address loaded, which adds one cycle to `busy`.
- R11: The address field and data bit do not change while a strobe is high, nor on the cycle the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request pulse; accepted when `busy` is low |
| req_addr | input | 8 | Bit address of the first bit |
| req_data | input | 16 | Value to write, least significant bit first |
| req_len | input | 5 | Number of bits; values above 16 are clamped |
| req_phy | input | 2 | Target PHY index |
| hold_cycles | input | 4 | Extra strobe-high cycles per bit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| csr_out | output | 32 | Modelled control register value |

## Verification
The bench sweeps every PHY index, several hold counts and the lengths 0, 1, 2, 5, 16, 17 and 31. It uses alternating, walking and all-ones data patterns, so each strobe position, bit ordering and clamp is observed. Start addresses near 0xFF show the address wraparound. Data patterns whose neighbouring bits differ show whether the bits go out least significant first.

Every cycle of every request is compared against an arithmetic model of the register, `busy` and `done`. A build without clearing and a build with clearing run side by side, so the one-cycle clear and its shifted timing are checked against the plain timing. A second request injected mid-transfer shows whether it is ignored.

// File: rtl/pcw_pkg.sv
// Package: shared phase encoding for the PHY bit-serial configuration writer.
// Assumes: nothing beyond standard SystemVerilog.
package pcw_pkg;

    // Per-bit sequencing phases; PH_CLEAR is only entered in the clearing variant.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CLEAR = 3'd1,
        PH_ADDR  = 3'd2,
        PH_SLOW  = 3'd3,
        PH_DATA  = 3'd4,
        PH_HIGH  = 3'd5,
        PH_FALL  = 3'd6
    } phase_e;

endpackage

// File: rtl/pcw_req_capture.sv
// Module: pcw_req_capture
// Holds the accepted request and serves the address and data bit of the
// bit currently being written. Also provides the clamped length of the
// incoming request so the top can tell empty requests apart.
// Assumes: accept is asserted for exactly one cycle per accepted request.
module pcw_req_capture #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 8,
    parameter int LEN_IN_W = 5,
    parameter int PHY_W    = 2,
    parameter int HOLD_W   = 4,
    parameter int LEN_W    = $clog2(DATA_W + 1),
    parameter int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [LEN_IN_W-1:0] req_len,
    input  logic [PHY_W-1:0]    req_phy,
    input  logic [HOLD_W-1:0]   hold_cycles,
    input  logic [IDX_W-1:0]    bit_idx,
    output logic [LEN_W-1:0]    in_len_clamped,
    output logic [LEN_W-1:0]    len_q,
    output logic [PHY_W-1:0]    phy_q,
    output logic [HOLD_W-1:0]   hold_q,
    output logic [ADDR_W-1:0]   bit_addr,
    output logic                data_bit
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Clamp the requested length to the data word width.
    always_comb begin
        if (32'(req_len) > 32'(DATA_W))
            in_len_clamped = LEN_W'(DATA_W);
        else
            in_len_clamped = LEN_W'(req_len);
    end

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            len_q  <= '0;
            phy_q  <= '0;
            hold_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            len_q  <= in_len_clamped;
            phy_q  <= req_phy;
            hold_q <= hold_cycles;
        end
    end

    // Address and value of the current bit, least significant first.
    always_comb begin
        bit_addr = addr_q + ADDR_W'(bit_idx);
        data_bit = data_q[bit_idx];
    end

endmodule

// File: rtl/pcw_hold_timer.sv
// Module: pcw_hold_timer
// Down-counter that sets how many extra cycles the strobe stays high.
// Assumes: load and dec are never asserted together.
module pcw_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              dec,
    output logic              expired
);

    logic [HOLD_W-1:0] cnt_q;

    // Load the hold count, then count down once per strobe-high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - HOLD_W'(1);
    end

    // Expiry flag used by the sequencer.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/pcw_bit_sequencer.sv
// Module: pcw_bit_sequencer
// Phase machine that walks each bit through address, strobe-low, data,
// strobe-high and strobe-fall, then advances the bit index.
// Assumes: start and start_empty are mutually exclusive and are only
// raised while the machine is idle; len is non-zero whenever start is high.
module pcw_bit_sequencer
    import pcw_pkg::*;
#(
    parameter int LEN_W          = 5,
    parameter int IDX_W          = 4,
    parameter bit CLEAR_ON_START = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_empty,
    input  logic [LEN_W-1:0] len,
    input  logic             hold_expired,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             done,
    output logic             hold_load,
    output logic             hold_dec
);

    logic last_bit;

    // Flag the final bit of the request.
    always_comb last_bit = ((LEN_W'(bit_idx) + LEN_W'(1)) == len);

    // Advance the phase, the bit index and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        bit_idx <= '0;
                        phase   <= CLEAR_ON_START ? PH_CLEAR : PH_ADDR;
                    end else if (start_empty) begin
                        done <= 1'b1;
                    end
                end
                PH_CLEAR: phase <= PH_ADDR;
                PH_ADDR:  phase <= PH_SLOW;
                PH_SLOW:  phase <= PH_DATA;
                PH_DATA:  phase <= PH_HIGH;
                PH_HIGH: begin
                    if (hold_expired)
                        phase <= PH_FALL;
                end
                PH_FALL: begin
                    if (last_bit) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + IDX_W'(1);
                        phase   <= PH_ADDR;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Hold timer controls: load on the data phase, count down while high.
    always_comb begin
        hold_load = (phase == PH_DATA);
        hold_dec  = (phase == PH_HIGH) && !hold_expired;
    end

endmodule

// File: rtl/pcw_csr_drive.sv
// Module: pcw_csr_drive
// Owns the modelled control register: address field, data bit and one
// strobe per PHY at bit 2*n. Every other bit reads as zero.
// Assumes: NUM_PHY <= 4, so the strobes stay below the data bit.
module pcw_csr_drive
    import pcw_pkg::*;
#(
    parameter int NUM_PHY = 4,
    parameter int ADDR_W  = 8,
    parameter int REG_W   = 32,
    parameter int PHY_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              data_bit,
    input  logic [PHY_W-1:0]  phy_sel,
    output logic [REG_W-1:0]  csr_out
);

    localparam int ADDR_LSB = 8;
    localparam int DATA_POS = 7;

    logic [ADDR_W-1:0]  addr_q;
    logic               data_q;
    logic [NUM_PHY-1:0] strobe_q;

    // Address field and data bit follow their own phases; clear zeroes both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= 1'b0;
        end else if (phase == PH_CLEAR) begin
            addr_q <= '0;
            data_q <= 1'b0;
        end else begin
            if (phase == PH_ADDR) addr_q <= bit_addr;
            if (phase == PH_DATA) data_q <= data_bit;
        end
    end

    // One strobe register per PHY, driven only while that PHY is selected.
    for (genvar n = 0; n < NUM_PHY; n++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (!rst_n)
                strobe_q[n] <= 1'b0;
            else if (phase == PH_CLEAR)
                strobe_q[n] <= 1'b0;
            else if (phy_sel == PHY_W'(n)) begin
                if (phase == PH_HIGH)
                    strobe_q[n] <= 1'b1;
                else if (phase == PH_SLOW || phase == PH_FALL)
                    strobe_q[n] <= 1'b0;
            end
        end
    end

    // Assemble the register image bit by bit.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b >= ADDR_LSB && b < ADDR_LSB + ADDR_W) begin : g_addr
            assign csr_out[b] = addr_q[b - ADDR_LSB];
        end else if (b == DATA_POS) begin : g_data
            assign csr_out[b] = data_q;
        end else if ((b % 2) == 0 && (b / 2) < NUM_PHY) begin : g_stb
            assign csr_out[b] = strobe_q[b / 2];
        end else begin : g_zero
            assign csr_out[b] = 1'b0;
        end
    end

endmodule

// File: rtl/phy_cfg_serial_writer.sv
// Module: phy_cfg_serial_writer (top)
// Accepts a bit-run request and writes it, one bit at a time and least
// significant bit first, into a PHY through the modelled shared control register.
// Assumes: req_phy < NUM_PHY; requests are presented as single-cycle pulses.
module phy_cfg_serial_writer
    import pcw_pkg::*;
#(
    parameter int NUM_PHY        = 4,
    parameter int DATA_W         = 16,
    parameter int ADDR_W         = 8,
    parameter int LEN_IN_W       = 5,
    parameter int HOLD_W         = 4,
    parameter int REG_W          = 32,
    parameter bit CLEAR_ON_START = 1'b0,
    localparam int PHY_W         = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [LEN_IN_W-1:0] req_len,
    input  logic [PHY_W-1:0]    req_phy,
    input  logic [HOLD_W-1:0]   hold_cycles,
    output logic                busy,
    output logic                done,
    output logic [REG_W-1:0]    csr_out
);

    localparam int LEN_W = $clog2(DATA_W + 1);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    phase_e            phase;
    logic [IDX_W-1:0]  bit_idx;
    logic [LEN_W-1:0]  in_len_clamped;
    logic [LEN_W-1:0]  len_q;
    logic [PHY_W-1:0]  phy_q;
    logic [HOLD_W-1:0] hold_q;
    logic [ADDR_W-1:0] bit_addr;
    logic              data_bit;
    logic              accept;
    logic              start;
    logic              start_empty;
    logic              hold_load;
    logic              hold_dec;
    logic              hold_expired;

    // Request acceptance: only while idle, split by empty/non-empty length.
    always_comb begin
        busy        = (phase != PH_IDLE);
        accept      = req_valid && !busy;
        start       = accept && (in_len_clamped != '0);
        start_empty = accept && (in_len_clamped == '0);
    end

    pcw_req_capture #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .LEN_IN_W (LEN_IN_W),
        .PHY_W    (PHY_W),
        .HOLD_W   (HOLD_W),
        .LEN_W    (LEN_W),
        .IDX_W    (IDX_W)
    ) u_cap (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (start),
        .req_addr       (req_addr),
        .req_data       (req_data),
        .req_len        (req_len),
        .req_phy        (req_phy),
        .hold_cycles    (hold_cycles),
        .bit_idx        (bit_idx),
        .in_len_clamped (in_len_clamped),
        .len_q          (len_q),
        .phy_q          (phy_q),
        .hold_q         (hold_q),
        .bit_addr       (bit_addr),
        .data_bit       (data_bit)
    );

    pcw_hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_q),
        .dec      (hold_dec),
        .expired  (hold_expired)
    );

    pcw_bit_sequencer #(
        .LEN_W          (LEN_W),
        .IDX_W          (IDX_W),
        .CLEAR_ON_START (CLEAR_ON_START)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_empty  (start_empty),
        .len          (len_q),
        .hold_expired (hold_expired),
        .phase        (phase),
        .bit_idx      (bit_idx),
        .done         (done),
        .hold_load    (hold_load),
        .hold_dec     (hold_dec)
    );

    pcw_csr_drive #(
        .NUM_PHY (NUM_PHY),
        .ADDR_W  (ADDR_W),
        .REG_W   (REG_W),
        .PHY_W   (PHY_W)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .bit_addr (bit_addr),
        .data_bit (data_bit),
        .phy_sel  (phy_q),
        .csr_out  (csr_out)
    );

endmodule

// File: rtl/pcw_checker.sv
// Module: pcw_checker
// Protocol properties on the top-level ports, bound into every instance.
// Assumes: strobes live at bits 2*n below bit 7, fields at [15:7].
module pcw_checker #(
    parameter int NUM_PHY = 4,
    parameter int REG_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [REG_W-1:0] csr_out
);

    // Mask of bits that are neither fields nor strobes.
    function automatic logic [REG_W-1:0] keep_mask_f();
        logic [REG_W-1:0] m;
        for (int b = 0; b < REG_W; b++) begin
            m[b] = !((b >= 7 && b <= 15) || ((b % 2) == 0 && (b / 2) < NUM_PHY));
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] KEEP_MASK = keep_mask_f();

    logic [NUM_PHY-1:0] strobes;
    logic               any_strobe;

    // Gather the strobe bits from the register image.
    always_comb begin
        for (int n = 0; n < NUM_PHY; n++) strobes[n] = csr_out[2 * n];
        any_strobe = |strobes;
    end

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    assert_keep_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(csr_out & KEEP_MASK));

    assert_idle_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !any_strobe);

    assert_busy_fall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fields_at_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_strobe) |-> $stable(csr_out[15:7]));

    assert_fields_while_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe && $past(any_strobe) |-> $stable(csr_out[15:7]));

endmodule

bind phy_cfg_serial_writer pcw_checker #(
    .NUM_PHY (NUM_PHY),
    .REG_W   (REG_W)
) u_pcw_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .csr_out (csr_out)
);

// File: tb/tb_phy_cfg_serial_writer.sv
module tb_phy_cfg_serial_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic [4:0]  req_len = '0;
    logic [1:0]  req_phy = '0;
    logic [3:0]  hold_cycles = '0;
    logic        busy_n, done_n, busy_c, done_c;
    logic [31:0] csr_n, csr_c;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] exp_csr [2];
    int cur_L, cur_P, cur_phy;
    logic [7:0]  cur_addr;
    logic [15:0] cur_data;

    always #5 clk = ~clk;

    phy_cfg_serial_writer #(.CLEAR_ON_START(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_len(req_len), .req_phy(req_phy),
        .hold_cycles(hold_cycles), .busy(busy_n), .done(done_n), .csr_out(csr_n));

    phy_cfg_serial_writer #(.CLEAR_ON_START(1'b1)) dut_clr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_len(req_len), .req_phy(req_phy),
        .hold_cycles(hold_cycles), .busy(busy_c), .done(done_c), .csr_out(csr_c));

    // Compare one build against the model after edge k of the current request.
    task automatic sample(input int d, input int k, input string tag);
        int kk, j, o;
        logic eb, ed;
        logic [31:0] a_csr;
        logic a_b, a_d;
        kk = k - d;
        if (k == 0) begin
            eb = (cur_L > 0); ed = (cur_L == 0);
        end else if (cur_L == 0) begin
            eb = 1'b0; ed = 1'b0;
        end else if (d == 1 && k == 1) begin
            exp_csr[d] = '0; eb = 1'b1; ed = 1'b0;   // R10 clear cycle
        end else if (kk <= cur_L * cur_P) begin
            j = (kk - 1) / cur_P;
            o = (kk - 1) % cur_P;
            if (o == 0) exp_csr[d][15:8] = 8'(cur_addr + 8'(j));
            if (o == 2) exp_csr[d][7] = cur_data[j];
            if (o == 3) exp_csr[d][2 * cur_phy] = 1'b1;
            if (o == cur_P - 1) exp_csr[d][2 * cur_phy] = 1'b0;
            eb = (kk < cur_L * cur_P);
            ed = (kk == cur_L * cur_P);
        end else begin
            eb = 1'b0; ed = 1'b0;
        end
        a_csr = (d == 1) ? csr_c : csr_n;
        a_b   = (d == 1) ? busy_c : busy_n;
        a_d   = (d == 1) ? done_c : done_n;
        vectors++;
        if (a_csr !== exp_csr[d] || a_b !== eb || a_d !== ed) begin
            fails++;
            $display("FAIL %s%s dut%0d k=%0d csr/busy/done act=%h/%b/%b exp=%h/%b/%b",
                     tag, (d == 1) ? " R10" : "", d, k, a_csr, a_b, a_d, exp_csr[d], eb, ed);
        end
    endtask

    // Issue one request and check both builds on every cycle until idle.
    task automatic run_req(input logic [7:0] a, input logic [15:0] dt, input int len,
                           input int phy, input int hold, input bit poke, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = dt; req_len = 5'(len);
        req_phy = 2'(phy); hold_cycles = 4'(hold);
        cur_addr = a; cur_data = dt; cur_phy = phy; cur_P = hold + 5;
        cur_L = (len > 16) ? 16 : len;                 // R7 clamp
        for (int k = 0; k <= cur_L * cur_P + 2; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            sample(0, k, tag);
            sample(1, k, tag);
            if (poke && k == 2 && cur_L > 0) begin     // R8 request while busy
                req_valid = 1'b1; req_addr = ~a; req_data = ~dt;
                req_len = 5'd3; req_phy = 2'(phy ^ 1); hold_cycles = 4'd0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R5 watchdog expired act=busy exp=idle");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        exp_csr[0] = '0; exp_csr[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        vectors++;
        if (csr_n !== '0 || csr_c !== '0 || busy_n || busy_c || done_n || done_c) begin
            fails++;
            $display("FAIL R1 reset act=%h/%h exp=0", csr_n, csr_c);
        end
        // Typical configuration writes
        run_req(8'h0C, 16'h0001, 1, 0, 0, 0, "R2 R3 R4");
        run_req(8'h20, 16'h0014, 5, 1, 1, 0, "R2 R3 R4");
        run_req(8'h2A, 16'h0003, 2, 2, 0, 0, "R2 R3 R4");
        run_req(8'h3C, 16'h0002, 2, 3, 2, 0, "R2 R3 R4");
        run_req(8'h3C, 16'h0000, 2, 3, 0, 0, "R2 R3 R4");
        // Sweep of PHY index, hold count, length and data pattern
        for (int phy = 0; phy < 4; phy++) begin
            for (int hold = 0; hold < 3; hold++) begin
                for (int li = 0; li < 7; li++) begin
                    int len;
                    logic [15:0] pat;
                    case (li)
                        0: len = 0; 1: len = 1; 2: len = 2; 3: len = 5;
                        4: len = 16; 5: len = 17; default: len = 31;
                    endcase
                    pat = (hold == 0) ? 16'hA5C3 : (hold == 1) ? 16'h0F0F : 16'hFFFF;
                    pat = pat ^ 16'(1 << (phy * 3 + li));
                    run_req(8'(8'hF8 + phy * 16 + li), pat, len, phy, hold, 0,
                            (len == 0) ? "R6" : (len > 16) ? "R7 R3" : "R3 R4 R9 R11");
                end
            end
        end
        // R8 interference while busy
        run_req(8'h10, 16'h1234, 4, 1, 1, 1, "R8");
        run_req(8'hFE, 16'hC0DE, 16, 2, 0, 1, "R8 R3");
        // Back-to-back empty then full request (R6, R5)
        run_req(8'h55, 16'hFFFF, 0, 0, 0, 0, "R6");
        run_req(8'h55, 16'h8001, 16, 0, 3, 0, "R5 R4");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule